// File: doc/BRIEF.md
# Deserializer Clock Phase Alignment Controller

This block brings up a serial video receive link without help from software. It first pulses the receive PLL reset and then waits for the PLL to report lock. It then moves a fine phase-shift control one step at a time so that the sampling point ends up in the middle of the range of phases where the deserialized clock word reads correctly. Once it is centred, it keeps watching both the lock and the raw clock word, and it starts bring-up again as soon as either one goes bad.

The search has four parts. The controller leaves any valid region it starts inside and takes one extra step forward. It then steps forward until it reaches the next valid region. It crosses that region while counting its width. Finally it steps back by half of that width. A position counts as valid only after a long run of consecutive correct samples, so an edge that is only marginal is rejected. The deserializer, the PLL and the phase-shift primitive sit outside the block. The block talks to the primitive through a one-cycle request, a direction bit and a done level.

Top module: `phalign_ctrl`

## Requirements
- R1: While reset is held and directly after it, `state_o` reads 0, `pll_rst_o` is high, and `ps_req_o`, `aligned_o`, `align_ok_o` and `align_fail_o` are all low.
- R2: The status code in `state_o` is 0 Reset, 1 ExitReset, 2 Lock, 3 Align and 4 Watch. Reset lasts one cycle and drives the PLL reset high. ExitReset lasts one cycle and releases the PLL reset. Lock holds until `pll_lock_i` is seen high, and the block then enters Align.
- R3: A clock word is correct only when it equals 7'b1100011. A filtered check passes only after 128 consecutive correct samples, and it fails on the first incorrect sample.
- R4: `ps_req_o` is a one-cycle pulse. `ps_dir_o` is set with the pulse (1 forward, 0 backward) and holds its value between pulses. A request is issued only while `ps_done_i` is high. A step completes when `ps_done_i` is seen high in a cycle after the pulse.
- R5: Alignment steps forward while the filtered check passes, then takes one extra forward step, then steps forward until the filtered check passes.
- R6: If the seek needs more than 1024 forward steps, `align_fail_o` pulses for one cycle and the block returns to Reset. With a word that is never correct, this gives 1026 forward requests.
- R7: On reaching the valid region the width counter starts at 1. The block steps forward and adds one to the width on every further passing check. It then issues width/2 backward steps (integer division), so the final phase is the first failing position minus width/2.
- R8: Losing `pll_lock_i` during Align or Watch returns the block to Reset on the next clock edge.
- R9: In Watch, a single incorrect clock word returns the block to Reset on the next clock edge, with no filtering.
- R10: `align_ok_o` pulses for exactly the first cycle of Watch. `aligned_o` is high exactly while the block is in Watch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock_i | input | 1 | Receive PLL lock indication |
| clk_word_i | input | WORD_W (7) | Deserialized sample of the link clock |
| ps_done_i | input | 1 | Phase-shift primitive idle/complete level |
| pll_rst_o | output | 1 | Receive PLL reset |
| ps_req_o | output | 1 | One-cycle phase-step request |
| ps_dir_o | output | 1 | Step direction, 1 forward, 0 backward |
| state_o | output | 3 | Status code of the bring-up sequence |
| aligned_o | output | 1 | High while centred and watching |
| align_ok_o | output | 1 | One-cycle pulse on reaching Watch |
| align_fail_o | output | 1 | One-cycle pulse when the seek limit is exceeded |

## Verification
The bench drives a modelled phase line of 64 positions. The valid region moves between runs, and the checks compare the final phase and the forward and backward step counts against closed-form values. An even window of 10, an odd window of 7 and a window of one separate the width/2 rounding and the case with no backward step. Starting inside the window and starting outside it separate the leave phase from the seek phase, and a start that forces the seek to wrap past position 63 exercises the wrap. A region edge that fails only once every 64 cycles shows that the filter rejects positions which are correct for most samples. A word that is never correct exposes the seek limit, and single-cycle word glitches and lock drops, in Align and in Watch, show the restart paths.

// File: rtl/phalign_pkg.sv
package phalign_pkg;

    typedef enum logic [3:0] {
        S_RESET,
        S_EXIT,
        S_LOCK,
        S_LEAVE_CHK,
        S_LEAVE_STEP,
        S_PAST_STEP,
        S_SEEK_CHK,
        S_SEEK_STEP,
        S_WIN_STEP,
        S_WIN_CHK,
        S_CTR_STEP,
        S_WATCH
    } seq_state_e;

    localparam logic [2:0] CODE_RESET = 3'd0;
    localparam logic [2:0] CODE_EXIT  = 3'd1;
    localparam logic [2:0] CODE_LOCK  = 3'd2;
    localparam logic [2:0] CODE_ALIGN = 3'd3;
    localparam logic [2:0] CODE_WATCH = 3'd4;

    function automatic logic [2:0] status_code(seq_state_e s);
        case (s)
            S_RESET: return CODE_RESET;
            S_EXIT:  return CODE_EXIT;
            S_LOCK:  return CODE_LOCK;
            S_WATCH: return CODE_WATCH;
            default: return CODE_ALIGN;
        endcase
    endfunction

    function automatic logic is_check(seq_state_e s);
        return (s == S_LEAVE_CHK) || (s == S_SEEK_CHK) || (s == S_WIN_CHK);
    endfunction

    function automatic logic is_step(seq_state_e s);
        return (s == S_LEAVE_STEP) || (s == S_PAST_STEP) || (s == S_SEEK_STEP)
            || (s == S_WIN_STEP) || (s == S_CTR_STEP);
    endfunction

endpackage

// File: rtl/phalign_filter.sv
module phalign_filter #(
    parameter int WORD_W     = 7,
    parameter logic [WORD_W-1:0] GOOD_WORD = 7'b1100011,
    parameter int FILTER_LEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              pass_o,
    output logic              fail_o
);
    localparam int CNT_W = (FILTER_LEN > 1) ? $clog2(FILTER_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILTER_LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             good;

    always_comb begin
        good   = (word_i == GOOD_WORD);
        pass_o = run_i && good && (cnt_q == LAST);
        fail_o = run_i && !good;
        cnt_d  = '0;
        if (run_i && good && !pass_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: an incorrect sample restarts the run of correct samples
    a_r3_bad_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && word_i != GOOD_WORD) |=> (cnt_q == '0));

endmodule

// File: rtl/phalign_stepper.sv
module phalign_stepper (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic dir_i,
    input  logic done_i,
    output logic req_o,
    output logic dir_o,
    output logic fin_o
);
    typedef struct packed {
        logic issued;
        logic req;
        logic dir;
    } step_t;

    step_t d, q;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        fin_o = 1'b0;
        if (!go_i) begin
            d.issued = 1'b0;
        end else if (!q.issued) begin
            if (done_i) begin
                d.req    = 1'b1;
                d.dir    = dir_i;
                d.issued = 1'b1;
            end
        end else if (!q.req && done_i) begin
            fin_o    = 1'b1;
            d.issued = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_o = q.req;
    assign dir_o = q.dir;

    a_r4_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        q.req |=> !q.req);
    a_r4_dir_moves_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.dir) |-> q.req);
    a_r4_req_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.req) |-> $past(done_i));

endmodule

// File: rtl/phalign_ctrl.sv
module phalign_ctrl
    import phalign_pkg::*;
#(
    parameter int WORD_W     = 7,
    parameter logic [WORD_W-1:0] GOOD_WORD = 7'b1100011,
    parameter int FILTER_LEN = 128,
    parameter int SEEK_MAX   = 1024,
    parameter int WIN_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_lock_i,
    input  logic [WORD_W-1:0] clk_word_i,
    input  logic              ps_done_i,
    output logic              pll_rst_o,
    output logic              ps_req_o,
    output logic              ps_dir_o,
    output logic [2:0]        state_o,
    output logic              aligned_o,
    output logic              align_ok_o,
    output logic              align_fail_o
);
    localparam int SCNT_W = $clog2(SEEK_MAX + 1);
    localparam logic [SCNT_W-1:0] SEEK_LIM = SCNT_W'(SEEK_MAX);

    typedef struct packed {
        seq_state_e       st;
        logic             pll_rst;
        logic [SCNT_W-1:0] scnt;
        logic [WIN_W-1:0]  wcnt;
        logic [WIN_W-1:0]  bcnt;
        logic             ok;
        logic             fail;
    } ctl_t;

    ctl_t d, q;

    logic filt_run, filt_pass, filt_fail;
    logic step_go, step_dir, step_fin;
    logic in_align;
    logic [WIN_W-1:0] half;

    phalign_filter #(
        .WORD_W     (WORD_W),
        .GOOD_WORD  (GOOD_WORD),
        .FILTER_LEN (FILTER_LEN)
    ) filt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (filt_run),
        .word_i (clk_word_i),
        .pass_o (filt_pass),
        .fail_o (filt_fail)
    );

    phalign_stepper step_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (step_go),
        .dir_i  (step_dir),
        .done_i (ps_done_i),
        .req_o  (ps_req_o),
        .dir_o  (ps_dir_o),
        .fin_o  (step_fin)
    );

    always_comb begin
        in_align = is_check(q.st) || is_step(q.st);
        filt_run = is_check(q.st) && pll_lock_i;
        step_go  = is_step(q.st) && pll_lock_i;
        step_dir = (q.st != S_CTR_STEP);
        half     = q.wcnt >> 1;

        d      = q;
        d.ok   = 1'b0;
        d.fail = 1'b0;

        unique case (q.st)
            S_RESET: begin
                d.pll_rst = 1'b1;
                d.st      = S_EXIT;
            end
            S_EXIT: begin
                if (q.pll_rst) begin
                    d.pll_rst = 1'b0;
                    d.st      = S_LOCK;
                end
            end
            S_LOCK: begin
                if (pll_lock_i) d.st = S_LEAVE_CHK;
            end
            S_LEAVE_CHK: begin
                if (filt_pass)      d.st = S_LEAVE_STEP;
                else if (filt_fail) d.st = S_PAST_STEP;
            end
            S_LEAVE_STEP: begin
                if (step_fin) d.st = S_LEAVE_CHK;
            end
            S_PAST_STEP: begin
                if (step_fin) begin
                    d.scnt = '0;
                    d.st   = S_SEEK_CHK;
                end
            end
            S_SEEK_CHK: begin
                if (filt_pass) begin
                    d.wcnt = WIN_W'(1);
                    d.st   = S_WIN_STEP;
                end else if (filt_fail) begin
                    d.st = S_SEEK_STEP;
                end
            end
            S_SEEK_STEP: begin
                if (step_fin) begin
                    if (q.scnt == SEEK_LIM) begin
                        d.fail = 1'b1;
                        d.st   = S_RESET;
                    end else begin
                        d.scnt = q.scnt + 1'b1;
                        d.st   = S_SEEK_CHK;
                    end
                end
            end
            S_WIN_STEP: begin
                if (step_fin) d.st = S_WIN_CHK;
            end
            S_WIN_CHK: begin
                if (filt_pass) begin
                    if (q.wcnt != '1) d.wcnt = q.wcnt + 1'b1;
                    d.st = S_WIN_STEP;
                end else if (filt_fail) begin
                    if (half == '0) begin
                        d.ok = 1'b1;
                        d.st = S_WATCH;
                    end else begin
                        d.bcnt = half;
                        d.st   = S_CTR_STEP;
                    end
                end
            end
            S_CTR_STEP: begin
                if (step_fin) begin
                    if (q.bcnt == WIN_W'(1)) begin
                        d.ok = 1'b1;
                        d.st = S_WATCH;
                    end else begin
                        d.bcnt = q.bcnt - 1'b1;
                    end
                end
            end
            S_WATCH: begin
                if (!pll_lock_i || clk_word_i != GOOD_WORD) d.st = S_RESET;
            end
            default: d.st = S_RESET;
        endcase

        if (in_align && !pll_lock_i) begin
            d.st = S_RESET;
            d.ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= S_RESET;
            q.pll_rst <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pll_rst_o    = q.pll_rst;
    assign state_o      = status_code(q.st);
    assign aligned_o    = (q.st == S_WATCH);
    assign align_ok_o   = q.ok;
    assign align_fail_o = q.fail;

    a_r2_exit_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_EXIT) |=> (q.st == S_LOCK && !pll_rst_o));
    a_r8_lock_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (in_align && !pll_lock_i) |=> (state_o == CODE_RESET));
    a_r9_watch_glitch: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_o && clk_word_i != GOOD_WORD) |=> (state_o == CODE_RESET));
    a_r10_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
        align_ok_o |=> !align_ok_o);
    a_r10_ok_in_watch: assert property (@(posedge clk) disable iff (!rst_n)
        align_ok_o |-> aligned_o);
    a_r6_fail_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        align_fail_o |-> (state_o == CODE_RESET));

endmodule

// File: tb/phalign_ctrl_tb_top.sv
module phalign_ctrl_tb_top;

    localparam logic [6:0] GOOD = 7'b1100011;
    localparam int NPH = 64;
    localparam int FLEN = 128;
    localparam int SMAX = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_lock;
    logic [6:0] clk_word;
    logic ps_done;
    logic pll_rst, ps_req, ps_dir, aligned, align_ok, align_fail;
    logic [2:0] state;

    always #5 clk = ~clk;

    phalign_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pll_lock_i   (pll_lock),
        .clk_word_i   (clk_word),
        .ps_done_i    (ps_done),
        .pll_rst_o    (pll_rst),
        .ps_req_o     (ps_req),
        .ps_dir_o     (ps_dir),
        .state_o      (state),
        .aligned_o    (aligned),
        .align_ok_o   (align_ok),
        .align_fail_o (align_fail)
    );

    int n_vec = 0;
    int n_bad = 0;

    // environment: PLL, phase line, phase-shift primitive
    int  phase = 5;
    int  lo = 20, hi = 29;
    int  flaky_ph = -1;
    bit  force_bad = 0;
    bit  inj_bad = 0;
    bit  lock_en = 1;
    int  settle = 0;
    int  busy = 0;
    bit  pend_dir = 0;
    int  tick = 0;
    int  fwd_cnt = 0, back_cnt = 0;

    always @(posedge clk) begin
        tick <= tick + 1;
        if (pll_rst) settle <= 0;
        else if (settle < 4) settle <= settle + 1;
    end

    assign pll_lock = lock_en && (settle >= 4);

    always_comb begin
        bit ok;
        ok = !force_bad && !inj_bad && (phase >= lo) && (phase <= hi);
        if (phase == flaky_ph && (tick % 64) == 0) ok = 0;
        if (inj_bad) clk_word = 7'b1100010;
        else clk_word = ok ? GOOD : 7'b0011100;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_done <= 1'b1;
            busy    <= 0;
        end else if (ps_req) begin
            ps_done  <= 1'b0;
            busy     <= 3;
            pend_dir <= ps_dir;
            if (ps_dir) fwd_cnt <= fwd_cnt + 1;
            else        back_cnt <= back_cnt + 1;
        end else if (busy != 0) begin
            busy <= busy - 1;
            if (busy == 1) begin
                ps_done <= 1'b1;
                phase   <= pend_dir ? (phase + 1) % NPH : (phase + NPH - 1) % NPH;
            end
        end
    end

    // reference model state
    logic [2:0] exp_state = 0;
    bit exp_pll = 1, exp_req = 0, exp_dir = 0, exp_ok = 0, exp_fail = 0;
    bit lk, gd, dn;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        chk(state === exp_state, "R2 state_o", int'(state), int'(exp_state));
        chk(pll_rst === exp_pll, "R2 pll_rst_o", int'(pll_rst), int'(exp_pll));
        chk(ps_req === exp_req, "R4 ps_req_o", int'(ps_req), int'(exp_req));
        chk(ps_dir === exp_dir, "R4 ps_dir_o", int'(ps_dir), int'(exp_dir));
        chk(aligned === (exp_state == 3'd4), "R10 aligned_o", int'(aligned), int'(exp_state == 3'd4));
        chk(align_ok === exp_ok, "R10 align_ok_o", int'(align_ok), int'(exp_ok));
        chk(align_fail === exp_fail, "R6 align_fail_o", int'(align_fail), int'(exp_fail));
        lk = pll_lock;
        gd = (clk_word == GOOD);
        dn = ps_done;
        @(negedge clk);
    endtask

    // r: 0 abort, 1 pass, 2 fail
    task automatic m_check(output int r);
        for (int k = 0; ; k++) begin
            cyc();
            if (!lk) begin r = 0; return; end
            if (!gd) begin r = 2; return; end
            if (k == FLEN - 1) begin r = 1; return; end
        end
    endtask

    task automatic m_step(input bit d, output int r);
        forever begin
            cyc();
            if (!lk) begin r = 0; return; end
            if (dn) break;
        end
        exp_req = 1; exp_dir = d;
        cyc();
        exp_req = 0;
        if (!lk) begin r = 0; return; end
        forever begin
            cyc();
            if (!lk) begin r = 0; return; end
            if (dn) break;
        end
        r = 1;
    endtask

    task automatic m_align(output int res);
        int r, n, w;
        forever begin
            m_check(r);
            if (r == 0) begin res = 0; return; end
            if (r == 2) break;
            m_step(1, r);
            if (r == 0) begin res = 0; return; end
        end
        m_step(1, r);
        if (r == 0) begin res = 0; return; end
        n = 0;
        forever begin
            m_check(r);
            if (r == 0) begin res = 0; return; end
            if (r == 1) break;
            m_step(1, r);
            if (r == 0) begin res = 0; return; end
            n++;
            if (n > SMAX) begin res = 2; return; end
        end
        w = 1;
        m_step(1, r);
        if (r == 0) begin res = 0; return; end
        forever begin
            m_check(r);
            if (r == 0) begin res = 0; return; end
            if (r == 2) break;
            w++;
            m_step(1, r);
            if (r == 0) begin res = 0; return; end
        end
        for (int i = 0; i < w / 2; i++) begin
            m_step(0, r);
            if (r == 0) begin res = 0; return; end
        end
        res = 1;
    endtask

    task automatic model();
        bit pend_fail = 0;
        int res;
        forever begin
            exp_state = 3'd0; exp_fail = pend_fail; pend_fail = 0;
            cyc();
            exp_fail = 0; exp_state = 3'd1; exp_pll = 1;
            cyc();
            exp_pll = 0; exp_state = 3'd2;
            do cyc(); while (!lk);
            exp_state = 3'd3;
            m_align(res);
            if (res == 2) pend_fail = 1;
            if (res == 1) begin
                exp_state = 3'd4; exp_ok = 1;
                forever begin
                    cyc();
                    exp_ok = 0;
                    if (!lk || !gd) break;
                end
            end
        end
    endtask

    task automatic edge_set();
        @(posedge clk); #1;
    endtask

    task automatic wait_ok();
        do @(negedge clk); while (!align_ok);
    endtask

    task automatic restart(input int nlo, input int nhi, input int nfl);
        edge_set(); lock_en = 0;
        repeat (3) edge_set();
        lo = nlo; hi = nhi; flaky_ph = nfl;
        fwd_cnt = 0; back_cnt = 0;
        lock_en = 1;
    endtask

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", wd);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(state == 3'd0, "R1 state_o in reset", int'(state), 0);
        chk(pll_rst == 1'b1, "R1 pll_rst_o in reset", int'(pll_rst), 1);
        chk(ps_req == 1'b0, "R1 ps_req_o in reset", int'(ps_req), 0);
        chk(aligned == 1'b0, "R1 aligned_o in reset", int'(aligned), 0);
        rst_n = 1'b1;
        fork
            model();
        join_none

        // start outside window 20..29
        wait_ok();
        chk(aligned == 1'b1, "R10 aligned after ok pulse", int'(aligned), 1);
        chk(phase == 25, "R7 centred phase even window", phase, 25);
        chk(fwd_cnt == 25, "R5 forward steps from outside", fwd_cnt, 25);
        chk(back_cnt == 5, "R7 backward steps even window", back_cnt, 5);

        // R9: one bad word in Watch, restart from inside the window
        repeat (20) edge_set();
        inj_bad = 1; fwd_cnt = 0; back_cnt = 0;
        edge_set(); inj_bad = 0;
        chk(state == 3'd0, "R9 single bad word leaves Watch", int'(state), 0);
        wait_ok();
        chk(phase == 25, "R5 realign with wrap", phase, 25);
        chk(fwd_cnt == 69, "R5 forward steps from inside", fwd_cnt, 69);

        // R8: lock loss in Watch
        edge_set(); lock_en = 0;
        edge_set();
        chk(state == 3'd0, "R8 lock loss in Watch", int'(state), 0);
        restart(40, 40, -1);
        wait_ok();
        chk(phase == 41, "R7 width one no back step", phase, 41);
        chk(back_cnt == 0, "R7 width one back count", back_cnt, 0);
        chk(fwd_cnt == 16, "R5 forward steps width one", fwd_cnt, 16);

        // odd window 10..16
        restart(10, 16, -1);
        wait_ok();
        chk(phase == 14, "R7 centred phase odd window", phase, 14);
        chk(back_cnt == 3, "R7 backward steps odd window", back_cnt, 3);

        // R3: marginal edge at 50 fails the filter
        restart(44, 50, 50);
        wait_ok();
        chk(phase == 47, "R3 flaky edge excluded", phase, 47);
        chk(fwd_cnt == 36, "R3 forward steps flaky", fwd_cnt, 36);

        // R8: lock loss during Align
        restart(20, 29, -1);
        do @(negedge clk); while (state != 3'd3);
        repeat (50) edge_set();
        chk(state == 3'd3, "R8 still aligning", int'(state), 3);
        lock_en = 0;
        edge_set();
        chk(state == 3'd0, "R8 lock loss in Align", int'(state), 0);

        // R6: never-correct word exhausts the seek
        force_bad = 1;
        restart(20, 29, -1);
        do @(negedge clk); while (!align_fail);
        chk(fwd_cnt == 1026, "R6 forward requests before failure", fwd_cnt, 1026);
        chk(back_cnt == 0, "R6 no backward requests", back_cnt, 0);
        edge_set(); force_bad = 0;
        wait_ok();
        chk(aligned == 1'b1, "R10 recovered after failure", int'(aligned), 1);
        repeat (5) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule